// File: doc/BRIEF.md
# Sampled Hysteretic Field Latch

This block converts a signed, already digitised magnetic field code into a single latched state bit with hysteresis. It sits behind a duty-cycled sensing front end: a power controller raises `awake_i` while the front end is powered and settling, and the sample is taken in the cycle where `awake_i` is first seen low again. That end-of-awake moment is the only time the latched state may move. During the sleep period the output keeps the last sampled decision, whatever the field input does.

Two signed thresholds are programmed at the ports. A field strictly above the operate threshold turns the output on, which drives it low. A field strictly below the release threshold turns it off, which drives it high. Anything between the two, the thresholds themselves included, keeps the previous state. After reset the output sits in the off state but is flagged as not yet meaningful until the first sample that lands outside the band. Every real flip of the latched value raises a one-cycle pulse. The power controller uses this pulse to move to a faster sampling rate while activity lasts. Typical settings are +36 for operate and -36 for release, which gives a band 72 codes wide. The design requires operate to be greater than release.

Top module: `hyst_field_latch`

## Requirements
- R1: In the cycle where `awake_i` is low and was high in the previous cycle (the sample strobe), a field strictly greater than `op_thr_i` makes `out_no_o` 0 from the following cycle onward.
- R2: At a sample strobe, a field strictly less than `rel_thr_i` makes `out_no_o` 1 from the following cycle onward.
- R3: At a sample strobe, a field with `rel_thr_i <= field <= op_thr_i` leaves `out_no_o` unchanged. This includes a field equal to either threshold.
- R4: `out_no_o` and `valid_o` change only in the cycle after a sample strobe. Field changes while awake, while asleep, or with `awake_i` held high have no effect.
- R5: While `rst_ni` is low, `out_no_o` is 1, `valid_o` is 0 and `changed_o` is 0. The falling-edge detector is cleared, so the first strobe needs `awake_i` to be seen high after reset.
- R6: `valid_o` goes to 1 after the first strobe whose field lies outside the band, and stays 1 until reset. An in-band strobe does not set it. While `valid_o` is 0, `out_no_o` is 1.
- R7: `changed_o` is 1 for exactly the one cycle in which `out_no_o` shows a new value, and is 0 otherwise. A first crossing below release after reset leaves the output at 1 and so gives no pulse.
- R8: `field_i`, `op_thr_i` and `rel_thr_i` are two's-complement signed values `FIELD_W` bits wide (12 by default), and the thresholds may be changed at any time. With `op_thr_i` at the most positive code, no field can turn the output on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awake_i | input | 1 | Awake window from the power controller; a sample is taken on its falling edge |
| field_i | input | FIELD_W | Signed field code |
| op_thr_i | input | FIELD_W | Signed operate threshold |
| rel_thr_i | input | FIELD_W | Signed release threshold |
| out_no_o | output | 1 | Latched state, active low (0 = on) |
| valid_o | output | 1 | State has been set by a crossing since reset |
| changed_o | output | 1 | One-cycle pulse on every flip of `out_no_o` |

## Verification
The hardest conditions to reach are samples that land exactly on a threshold at the strobe, and strobes taken while the latch already holds the side being crossed toward. These must move neither the output nor the change pulse. The stimulus reaches them with directed awake windows whose field sits at operate, at release, and one code beyond each. The field is changed freely during the windows and during the sleep gaps, so that only the value at the falling edge matters. A mid-run reset followed by a first release crossing checks the quiet start without a pulse. A run of random awake lengths, sleep gaps and field values is compared cycle by cycle against a behavioural model.

// File: rtl/hfl_pkg.sv
package hfl_pkg;
  typedef enum logic [1:0] {
    ZONE_BAND  = 2'd0,
    ZONE_ABOVE = 2'd1,
    ZONE_BELOW = 2'd2
  } zone_e;
endpackage

// File: rtl/hfl_zone_cmp.sv
module hfl_zone_cmp
  import hfl_pkg::*;
#(
  parameter int unsigned FIELD_W = 12
) (
  input  logic signed [FIELD_W-1:0] field_i,
  input  logic signed [FIELD_W-1:0] op_thr_i,
  input  logic signed [FIELD_W-1:0] rel_thr_i,
  output zone_e                     zone_o
);
  logic above, below;

  assign above = field_i > op_thr_i;
  assign below = field_i < rel_thr_i;

  // operate wins if thresholds are misprogrammed
  always_comb begin
    if (above)      zone_o = ZONE_ABOVE;
    else if (below) zone_o = ZONE_BELOW;
    else            zone_o = ZONE_BAND;
  end
endmodule

// File: rtl/hfl_wake_edge.sv
module hfl_wake_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic awake_i,
  output logic strobe_o
);
  logic awake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) awake_q <= 1'b0;
    else         awake_q <= awake_i;
  end

  assign strobe_o = awake_q & ~awake_i;
endmodule

// File: rtl/hfl_latch_core.sv
module hfl_latch_core
  import hfl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  strobe_i,
  input  zone_e zone_i,
  output logic  out_no_o,
  output logic  valid_o,
  output logic  changed_o
);
  logic out_q, valid_q, chg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= 1'b1;
      valid_q <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (strobe_i) begin
        unique case (zone_i)
          ZONE_ABOVE: begin
            out_q   <= 1'b0;
            valid_q <= 1'b1;
            chg_q   <= out_q;
          end
          ZONE_BELOW: begin
            out_q   <= 1'b1;
            valid_q <= 1'b1;
            chg_q   <= ~out_q;
          end
          default: ;
        endcase
      end
    end
  end

  assign out_no_o  = out_q;
  assign valid_o   = valid_q;
  assign changed_o = chg_q;
endmodule

// File: rtl/hyst_field_latch.sv
module hyst_field_latch
  import hfl_pkg::*;
#(
  parameter int unsigned FIELD_W = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      awake_i,
  input  logic signed [FIELD_W-1:0] field_i,
  input  logic signed [FIELD_W-1:0] op_thr_i,
  input  logic signed [FIELD_W-1:0] rel_thr_i,
  output logic                      out_no_o,
  output logic                      valid_o,
  output logic                      changed_o
);
  logic  sample_stb;
  zone_e zone;

  hfl_wake_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .awake_i  (awake_i),
    .strobe_o (sample_stb)
  );

  hfl_zone_cmp #(.FIELD_W(FIELD_W)) u_cmp (
    .field_i   (field_i),
    .op_thr_i  (op_thr_i),
    .rel_thr_i (rel_thr_i),
    .zone_o    (zone)
  );

  hfl_latch_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (sample_stb),
    .zone_i    (zone),
    .out_no_o  (out_no_o),
    .valid_o   (valid_o),
    .changed_o (changed_o)
  );
endmodule

// File: rtl/hyst_field_latch_chk.sv
module hyst_field_latch_chk #(
  parameter int unsigned FIELD_W = 12
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      strobe_i,
  input logic signed [FIELD_W-1:0] field_i,
  input logic signed [FIELD_W-1:0] op_thr_i,
  input logic signed [FIELD_W-1:0] rel_thr_i,
  input logic                      out_no_o,
  input logic                      valid_o,
  input logic                      changed_o
);
  AST_OP_TURNS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && (field_i > op_thr_i) |=> !out_no_o); // R1

  AST_REL_TURNS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && (field_i < rel_thr_i) && (op_thr_i > rel_thr_i) |=> out_no_o); // R2

  AST_BAND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && (field_i <= op_thr_i) && (field_i >= rel_thr_i) |=> $stable(out_no_o)); // R3

  AST_NO_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(out_no_o) && $stable(valid_o)); // R4

  AST_INVALID_IS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> out_no_o); // R6

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R6

  AST_PULSE_ON_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed_o |-> (out_no_o != $past(out_no_o))); // R7

  AST_FLIP_HAS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_no_o != $past(out_no_o)) |-> changed_o); // R7
endmodule

bind hyst_field_latch hyst_field_latch_chk #(.FIELD_W(FIELD_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .strobe_i  (sample_stb),
  .field_i   (field_i),
  .op_thr_i  (op_thr_i),
  .rel_thr_i (rel_thr_i),
  .out_no_o  (out_no_o),
  .valid_o   (valid_o),
  .changed_o (changed_o)
);

// File: tb/hyst_field_latch_tb_top.sv
`timescale 1ns/1ps
module hyst_field_latch_tb_top;
  localparam int W = 12;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                awake_i = 1'b0;
  logic signed [W-1:0] field_i = '0;
  logic signed [W-1:0] op_thr_i = 12'sd36;
  logic signed [W-1:0] rel_thr_i = -12'sd36;
  logic                out_no_o, valid_o, changed_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  // behavioural reference state
  bit m_prev_awake, m_out, m_valid, m_chg;

  always #2.5 clk_i = ~clk_i;

  hyst_field_latch #(.FIELD_W(W)) dut_i (
    .clk_i, .rst_ni, .awake_i, .field_i, .op_thr_i, .rel_thr_i,
    .out_no_o, .valid_o, .changed_o
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_prev_awake = 1'b0; m_out = 1'b1; m_valid = 1'b0; m_chg = 1'b0;
    end else begin
      bit fire, nv;
      fire = m_prev_awake && !awake_i;
      m_prev_awake = awake_i;
      m_chg = 1'b0;
      if (fire) begin
        nv = m_out;
        if (int'(field_i) > int'(op_thr_i)) nv = 1'b0;
        else if (int'(field_i) < int'(rel_thr_i)) nv = 1'b1;
        if (int'(field_i) > int'(op_thr_i) || int'(field_i) < int'(rel_thr_i)) m_valid = 1'b1;
        m_chg = (nv != m_out);
        m_out = nv;
      end
    end
  end

  always @(negedge clk_i) begin
    if (cmp_en && rst_ni) begin
      check("R4", "model out_no_o", int'(out_no_o), int'(m_out));
      check("R6", "model valid_o", int'(valid_o), int'(m_valid));
      check("R7", "model changed_o", int'(changed_o), int'(m_chg));
    end
  end

  // awake window of len cycles with field f at the falling edge; ends one cycle after strobe
  task automatic pulse(int f, int len);
    awake_i = 1'b1;
    for (int i = 0; i < len; i++) begin
      field_i = W'(f + 500 - 37 * i);
      @(negedge clk_i);
    end
    awake_i = 1'b0;
    field_i = W'(f);
    @(negedge clk_i);
    field_i = W'(-f);
  endtask

  task automatic sleep(int n);
    for (int i = 0; i < n; i++) begin
      field_i = W'((i % 2 == 0) ? 900 : -900);
      @(negedge clk_i);
    end
  endtask

  task automatic expect_state(string req, int o, int v, int c);
    check(req, "out_no_o", int'(out_no_o), o);
    check(req, "valid_o", int'(valid_o), v);
    check(req, "changed_o", int'(changed_o), c);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    expect_state("R5", 1, 0, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp_en = 1'b1;

    pulse(10, 3);             expect_state("R6", 1, 0, 0);  // in band: no valid
    sleep(4);                 expect_state("R4", 1, 0, 0);
    pulse(37, 2);             expect_state("R1", 0, 1, 1);
    sleep(1);                 check("R7", "pulse width", int'(changed_o), 0);
    pulse(36, 4);             expect_state("R3", 0, 1, 0);  // equal to operate
    pulse(-36, 2);            expect_state("R3", 0, 1, 0);  // equal to release
    pulse(0, 1);              expect_state("R3", 0, 1, 0);
    sleep(6);                 expect_state("R4", 0, 1, 0);
    pulse(-37, 3);            expect_state("R2", 1, 1, 1);
    pulse(-200, 2);           expect_state("R7", 1, 1, 0);  // already off

    // awake held high with large fields: no update
    awake_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      field_i = W'(1500);
      @(negedge clk_i);
    end
    expect_state("R4", 1, 1, 0);
    awake_i = 1'b0; field_i = W'(-5); @(negedge clk_i);
    expect_state("R3", 1, 1, 0);

    // reprogrammed thresholds
    op_thr_i = 12'sd500; rel_thr_i = -12'sd10;
    pulse(400, 2);            expect_state("R8", 1, 1, 0);
    pulse(501, 2);            expect_state("R8", 0, 1, 1);
    pulse(-10, 2);            expect_state("R8", 0, 1, 0);
    pulse(-11, 2);            expect_state("R8", 1, 1, 1);
    op_thr_i = 12'sd2047; rel_thr_i = -12'sd2048;
    pulse(2047, 2);           expect_state("R8", 1, 1, 0);
    pulse(-2048, 2);          expect_state("R8", 1, 1, 0);
    op_thr_i = -12'sd100; rel_thr_i = -12'sd300;
    pulse(-99, 2);            expect_state("R8", 0, 1, 1);

    // mid-run reset then first crossing below release: no pulse
    cmp_en = 1'b0;
    awake_i = 1'b1;
    rst_ni = 1'b0; @(negedge clk_i);
    expect_state("R5", 1, 0, 0);
    awake_i = 1'b0; @(negedge clk_i);
    rst_ni = 1'b1; @(negedge clk_i);
    cmp_en = 1'b1;
    expect_state("R5", 1, 0, 0);
    pulse(-301, 2);           expect_state("R7", 1, 1, 0);
    pulse(-50, 1);            expect_state("R1", 0, 1, 1);

    // random phase, compared against the model every cycle
    op_thr_i = 12'sd36; rel_thr_i = -12'sd36;
    for (int n = 0; n < 400; n++) begin
      int f;
      f = int'($urandom_range(0, 200)) - 100;
      pulse(f, int'($urandom_range(1, 5)));
      sleep(int'($urandom_range(0, 6)));
    end

    cmp_en = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule